// File: doc/BRIEF.md
# 100BASE-TX Scrambled MLT-3 Transmit Serializer

This block sits between a 4B/5B encoder and the analog line driver of a 100 Mbit/s twisted-pair port. It runs on the 125 MHz symbol clock. Every fifth cycle it accepts one 5-bit code group and shifts the group out one bit per cycle, least significant bit first. Each serial bit is XORed with the output of an 11-bit scrambler. The scrambled stream is NRZI encoded, and the NRZI transitions then step a three-level MLT-3 state machine. The 2-bit signed level drives the analog transmitter.

The scrambler seed is built from a 5-bit port address, so ports on one chip that carry identical data still radiate different bit patterns. If the encoder has no group ready when the block takes one, the block sends the IDLE group.

Top module: `mlt3_tx_serializer`

## Requirements
- R1: While `rst_n` is low and right after its release, `mlt3_level` is 2'b00 (level 0). The next non-zero level reached is +1.
- R2: The group is taken at the 5th rising edge after reset release and at every 5th rising edge after that, but only when `grp_load` is high at that edge. The 5 bits of the group are sent on the next 5 cycles, bit 0 first.
- R3: If `grp_load` is low at a take edge, the group 5'b11111 (IDLE) is sent instead. The frame before the first take edge is also IDLE.
- R4: The scrambler is an 11-bit state s reset to {1'b1, 5'b00000, port_addr}. Each cycle the key k = s[10] ^ s[8] is computed, the scrambled bit is data ^ k, and s shifts left with k entering at bit 0.
- R5: Two instances that get the same group stream but different `port_addr` values produce different `mlt3_level` sequences.
- R6: The NRZI stage toggles its level on every scrambled 1 and holds it on every scrambled 0.
- R7: An NRZI transition moves the MLT-3 output one step through the cycle 0, +1, 0, -1, 0. The encoding is 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1, and 2'b10 never appears. Without a transition the level holds.
- R8: A scrambled bit formed in the cycle before rising edge n shows up on `mlt3_level` after edge n+1.
- R9: `grp_load` and `grp_data` are ignored at every edge that is not a take edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 5 | Port address used to seed the scrambler |
| grp_data | input | 5 | Code group from the 4B/5B encoder |
| grp_load | input | 1 | Group on `grp_data` is valid at a take edge |
| mlt3_level | output | 2 | Signed MLT-3 level for the line driver |

## Verification
The first group is due at the 5th edge after reset, and its bit 0 affects the line level two edges after the cycle it is sent in, because the NRZI and MLT-3 stages each add one register. The bench model pops one code bit per cycle from a queue. It applies each bit to its MLT-3 state one edge late and compares the level half a cycle after every edge. A separate receiver-side descrambler in the bench rebuilds the groups from the level changes, and it is lined up with the two-edge delay so that the first recovered bit belongs to the cycle before edge 1.

// File: rtl/mlt3_tx_serializer.sv
module mlt3_tx_serializer #(
  parameter int GROUP_W = 5,
  parameter int ADDR_W  = 5,
  parameter int LFSR_W  = 11,
  parameter int TAP     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [GROUP_W-1:0] grp_data,
  input  logic              grp_load,
  output logic [1:0]        mlt3_level
);
  localparam int PW = $clog2(GROUP_W);
  localparam int PAD = LFSR_W - ADDR_W - 1;

  logic [PW-1:0]      phase;
  logic [GROUP_W-1:0] shreg;
  logic [LFSR_W-1:0]  lfsr;
  logic               nrzi_q, nrzi_d, dir_up;
  logic [1:0]         level;

  wire key      = lfsr[LFSR_W-1] ^ lfsr[TAP-1];
  wire code_bit = shreg[0] ^ key;
  wire take     = (phase == PW'(GROUP_W-1));
  wire step     = nrzi_q ^ nrzi_d;
  wire [LFSR_W-1:0] seed = {1'b1, {PAD{1'b0}}, port_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      shreg  <= '1;
      lfsr   <= seed;
      nrzi_q <= 1'b0;
      nrzi_d <= 1'b0;
      level  <= 2'b00;
      dir_up <= 1'b1;
    end else begin
      lfsr   <= {lfsr[LFSR_W-2:0], key};
      nrzi_q <= nrzi_q ^ code_bit;
      nrzi_d <= nrzi_q;
      if (take) begin
        phase <= '0;
        shreg <= grp_load ? grp_data : '1;
      end else begin
        phase <= phase + 1'b1;
        shreg <= shreg >> 1;
      end
      if (step) begin
        if (level != 2'b00) begin
          dir_up <= level[1];
          level  <= 2'b00;
        end else begin
          level  <= dir_up ? 2'b01 : 2'b11;
        end
      end
    end
  end

  assign mlt3_level = level;
endmodule

// File: rtl/mlt3_tx_chk.sv
module mlt3_tx_chk #(
  parameter int GROUP_W = 5,
  parameter int LFSR_W  = 11,
  parameter int PW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               grp_load,
  input logic [GROUP_W-1:0] grp_data,
  input logic [PW-1:0]      phase,
  input logic [GROUP_W-1:0] shreg,
  input logic [LFSR_W-1:0]  lfsr,
  input logic               nrzi_q,
  input logic               nrzi_d,
  input logic [1:0]         level
);
  wire take = (phase == PW'(GROUP_W-1));

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) level != 2'b10); // R7
  AST_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b00 |=> (level == 2'b00 || $stable(level))); // R7
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    nrzi_q == nrzi_d |=> $stable(level)); // R8
  AST_MOVE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    nrzi_q != nrzi_d |=> !$stable(level)); // R6
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PW'(GROUP_W-1)); // R2
  AST_TAKE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    take && grp_load |=> shreg == $past(grp_data)); // R2
  AST_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !grp_load |=> shreg == '1); // R3
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0); // R4
endmodule

bind mlt3_tx_serializer mlt3_tx_chk #(.GROUP_W(GROUP_W), .LFSR_W(LFSR_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_load(grp_load), .grp_data(grp_data),
  .phase(phase), .shreg(shreg), .lfsr(lfsr), .nrzi_q(nrzi_q),
  .nrzi_d(nrzi_d), .level(level));

// File: tb/tb_mlt3_tx_serializer.sv
module tb_mlt3_tx_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] grp_data = 5'd0;
  logic grp_load = 1'b0;
  logic [1:0] lvl_a, lvl_b;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mlt3_tx_serializer dut  (.clk(clk), .rst_n(rst_n), .port_addr(5'd6),  .grp_data(grp_data),
                           .grp_load(grp_load), .mlt3_level(lvl_a));
  mlt3_tx_serializer dut2 (.clk(clk), .rst_n(rst_n), .port_addr(5'd19), .grp_data(grp_data),
                           .grp_load(grp_load), .mlt3_level(lvl_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dec(input logic [1:0] v);
    return (v == 2'b01) ? 1 : (v == 2'b11) ? -1 : (v == 2'b00) ? 0 : 9;
  endfunction

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit tx_q[$];
    bit pend[$];
    logic [4:0] exp_grp[$];
    logic [10:0] s, rs;
    int lvl = 0, dir = 1, edges = 0, prev = 0, frame = 0, diffs = 0;
    bit rx_bits[$];
    s  = {1'b1, 5'b0, 5'd6};
    rs = s;
    for (int i = 0; i < 5; i++) tx_q.push_back(1'b1);
    exp_grp.push_back(5'h1f);

    repeat (3) @(negedge clk);
    chk(lvl_a == 2'b00, "R1 level in reset", dec(lvl_a), 0);
    rst_n = 1'b1;

    for (int c = 0; c < 600; c++) begin
      bit take, k, cb;
      take = (tx_q.size() == 1);
      grp_load = 1'b0;
      grp_data = 5'((c * 13) ^ 5'h15);
      if (take) begin
        frame++;
        if (frame % 4 != 3) begin
          grp_load = 1'b1;
          grp_data = 5'((frame * 11 + 3) % 32);
        end
      end else if (c % 3 == 1) begin
        grp_load = 1'b1;
      end
      k  = s[10] ^ s[8];
      cb = tx_q.pop_front() ^ k;
      s  = {s[9:0], k};
      if (take) begin
        logic [4:0] g;
        g = grp_load ? grp_data : 5'h1f;
        exp_grp.push_back(g);
        for (int b = 0; b < 5; b++) tx_q.push_back(g[b]);
      end
      @(posedge clk);
      edges++;
      if (pend.size() > 0 && pend.pop_front()) begin
        if (lvl != 0) begin
          dir = (lvl < 0) ? 1 : -1;
          lvl = 0;
        end else lvl = dir;
      end
      pend.push_back(cb);
      @(negedge clk);
      chk(dec(lvl_a) == lvl, "R6 R7 R8 line level", dec(lvl_a), lvl);
      if (lvl_a != lvl_b) diffs++;
      if (edges >= 2) begin
        bit code, rk;
        code = (dec(lvl_a) != prev);
        prev = dec(lvl_a);
        rk = rs[10] ^ rs[8];
        rs = {rs[9:0], rk};
        rx_bits.push_back(code ^ rk);
        if (rx_bits.size() == 5) begin
          logic [4:0] got, want;
          for (int b = 0; b < 5; b++) got[b] = rx_bits.pop_front();
          want = exp_grp.pop_front();
          chk(got == want, "R2 R3 R4 R9 descrambled group", got, want);
        end
      end
    end
    chk(diffs > 0, "R5 distinct streams per address", diffs, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule